// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the device side of a serial NOR flash in SPI mode 0. It oversamples the serial clock, chip select and data input with the system clock. It collects each command byte, most significant bit first, and drives the serial data output. The first byte after chip select falls is the opcode. Address, dummy and data bytes are counted after it.

Read-type commands stream bytes until chip select rises. These are the status read, the array read, the fast read and the three identification reads. Write-type commands take effect on the rising edge of chip select. They need the write-enable flag and a byte count that matches the command. These are page program, the erase commands and status write. An accepted write-type command sends a one-cycle request to a back end, whose busy time is modelled by a down-counter.

The array is a small behavioural memory of 2^MEM_AW bytes, indexed by the low address bits. A deep-sleep state blocks every command except the wake command.

Top module: `spif_cmd_front`

## Requirements
- R1: Bits are taken on the rising SCK edge, MSB first, and the output bit changes on the falling edge. Opcode 05h returns the status byte repeatedly until CS_n rises. The status byte is {stored bits 7..2, write-enable flag in bit 1, busy flag in bit 0}. The output is 0 whenever CS_n is high and after reset.
- R2: Opcode 06h sets the write-enable flag and 04h clears it. Each acts only when CS_n rises after exactly 8 bits. A CS_n rise in the middle of a byte cancels any command with no effect.
- R3: Opcode 03h takes three address bytes. Opcode 0Bh takes three address bytes and then one dummy byte. Both then stream array bytes from address bits [MEM_AW-1:0], incrementing and wrapping within the array.
- R4: Opcode 02h takes three address bytes, then data bytes that are stored at incrementing, wrapping addresses. When CS_n rises on a byte boundary after at least one data byte, each written location becomes its old value AND the new value.
- R5: Opcodes 20h, D8h and 52h with exactly three address bytes, and C7h or 60h with no further byte, set every array byte to FFh. Any other byte count does nothing.
- R6: Opcode 01h followed by exactly one data byte stores data bits 7..2 into status bits 7..2.
- R7: Program, erase and status-write commands do nothing and start no request while the write-enable flag is clear.
- R8: An accepted write-type command pulses op_start_o for one cycle. op_kind_o gives 0 for status write, 1 for program, 2 for sector/block erase and 3 for whole-array erase. op_addr_o gives the command address, or 0 for kinds 0 and 3. wip_o is then high for exactly BUSY_CYCLES cycles, and when it ends the write-enable flag clears.
- R9: While wip_o is high, every opcode other than 05h is ignored: it gives output 0 and has no effect.
- R10: Opcode ABh, after three dummy bytes, returns DEV_ID repeatedly. On a CS_n rise on a byte boundary it also leaves deep sleep.
- R11: Opcode 90h takes two dummy bytes and a selector byte. Selector bit 0 = 0 starts the output with MAN_ID and 1 starts it with DEV_ID. The output then alternates between the two.
- R12: Opcode 9Fh returns MAN_ID, LONG_ID[15:8], LONG_ID[7:0], repeating in that order.
- R13: Opcode B9h enters deep sleep after exactly 8 bits. In deep sleep every opcode except ABh is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data to the host |
| wip_o | output | 1 | Back-end operation in progress |
| op_start_o | output | 1 | One-cycle request to the back end |
| op_kind_o | output | 2 | Request kind, encoded as in R8 |
| op_addr_o | output | 24 | Request address |

## Verification
The hardest window to reach is the busy period. A command must arrive while the back-end counter is still running, and its lack of effect must then be shown from the pins. BUSY_CYCLES is set long enough to cover several whole transfers. Right after a program request, the stimulus issues an array read, a write-disable and an erase. It then reads the status to show that the flags, the request count and the streamed bytes are unchanged. Deep sleep is reached the same way: the stored status bits are first made nonzero, so that an all-zero status read proves the command was ignored.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam logic [7:0] OPC_WR_EN        = 8'h06;
    localparam logic [7:0] OPC_WR_DIS       = 8'h04;
    localparam logic [7:0] OPC_STAT_RD      = 8'h05;
    localparam logic [7:0] OPC_STAT_WR      = 8'h01;
    localparam logic [7:0] OPC_RD           = 8'h03;
    localparam logic [7:0] OPC_RD_FAST      = 8'h0B;
    localparam logic [7:0] OPC_PROG         = 8'h02;
    localparam logic [7:0] OPC_ERASE_SMALL  = 8'h20;
    localparam logic [7:0] OPC_ERASE_BLK_A  = 8'hD8;
    localparam logic [7:0] OPC_ERASE_BLK_B  = 8'h52;
    localparam logic [7:0] OPC_ERASE_ALL_A  = 8'hC7;
    localparam logic [7:0] OPC_ERASE_ALL_B  = 8'h60;
    localparam logic [7:0] OPC_SLEEP        = 8'hB9;
    localparam logic [7:0] OPC_WAKE_ID      = 8'hAB;
    localparam logic [7:0] OPC_ID_PAIR      = 8'h90;
    localparam logic [7:0] OPC_ID_LONG      = 8'h9F;

    typedef enum logic [1:0] {
        KIND_STATUS    = 2'd0,
        KIND_PROG      = 2'd1,
        KIND_ERASE     = 2'd2,
        KIND_ERASE_ALL = 2'd3
    } op_kind_e;

endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
    parameter int            N       = 3,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] level_o
);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.chain[i] <= RST_VAL;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/spif_busy.sv
module spif_busy #(
    parameter int CYCLES = 2000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } busy_t;

    busy_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (start_i) begin
            b_d.cnt = CW'(CYCLES);
        end else if (b_q.cnt != '0) begin
            b_d.cnt = b_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign busy_o = (b_q.cnt != '0);
    assign done_o = (b_q.cnt == CW'(1));

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.cnt != '0 && !start_i) |=> (b_q.cnt == $past(b_q.cnt) - CW'(1))); // R8

endmodule

// File: rtl/spif_cmd_front.sv
module spif_cmd_front
    import spif_pkg::*;
#(
    parameter int          MEM_AW      = 4,
    parameter int          BUSY_CYCLES = 2000,
    parameter logic [7:0]  MAN_ID      = 8'h1C,
    parameter logic [7:0]  DEV_ID      = 8'h11,
    parameter logic [15:0] LONG_ID     = 16'h3112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_i,
    input  logic        csn_i,
    input  logic        di_i,
    output logic        do_o,
    output logic        wip_o,
    output logic        op_start_o,
    output logic [1:0]  op_kind_o,
    output logic [23:0] op_addr_o
);

    localparam int MEM_N  = 1 << MEM_AW;
    localparam int ADDR_W = 24;
    localparam int BC_W   = 3;
    localparam logic [BC_W-1:0] BC_MAX = '1;

    typedef struct packed {
        logic                      sck_prev;
        logic                      csn_prev;
        logic [2:0]                bit_cnt;
        logic [BC_W-1:0]           byte_cnt;
        logic [6:0]                in_sr;
        logic [7:0]                opc;
        logic                      drop;
        logic [ADDR_W-1:0]         addr;
        logic [ADDR_W-1:0]         cmd_addr;
        logic [7:0]                out_sr;
        logic                      do_bit;
        logic                      id_sel;
        logic [1:0]                id_phase;
        logic [5:0]                wr_hi;
        logic                      wel;
        logic                      dp;
        logic [5:0]                st_hi;
        logic [MEM_N-1:0][7:0]     mem;
        logic [MEM_N-1:0][7:0]     pbuf;
        logic                      start;
        op_kind_e                  kind;
        logic [ADDR_W-1:0]         op_addr;
    } front_t;

    front_t q, d;

    logic [2:0] lvl;
    logic       busy_w;
    logic       busy_done;

    spif_sync #(
        .N       (3),
        .STAGES  (2),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sck_i, csn_i, di_i}),
        .level_o (lvl)
    );

    spif_busy #(
        .CYCLES  (BUSY_CYCLES)
    ) i_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.start),
        .busy_o  (busy_w),
        .done_o  (busy_done)
    );

    logic sck_l, csn_l, di_l;
    assign sck_l = lvl[2];
    assign csn_l = lvl[1];
    assign di_l  = lvl[0];

    always_comb begin
        logic               sck_rise, sck_fall, cs_rise;
        logic [7:0]         b;
        logic [7:0]         nxt;
        logic [7:0]         status;
        logic [ADDR_W-1:0]  addr_now;
        logic               boundary;

        d        = q;
        d.start  = 1'b0;
        d.sck_prev = sck_l;
        d.csn_prev = csn_l;

        sck_rise = sck_l & ~q.sck_prev;
        sck_fall = ~sck_l & q.sck_prev;
        cs_rise  = csn_l & ~q.csn_prev;
        b        = {q.in_sr, di_l};
        nxt      = 8'h00;
        status   = {q.st_hi, q.wel, busy_w};
        addr_now = (q.byte_cnt <= BC_W'(3)) ? {q.addr[15:0], b} : q.addr;
        boundary = (q.bit_cnt == 3'd0) && (q.byte_cnt != '0) && !q.drop;

        if (csn_l) begin
            if (cs_rise && boundary) begin
                case (q.opc)
                    OPC_WR_EN:  if (q.byte_cnt == BC_W'(1)) d.wel = 1'b1;
                    OPC_WR_DIS: if (q.byte_cnt == BC_W'(1)) d.wel = 1'b0;
                    OPC_SLEEP:  if (q.byte_cnt == BC_W'(1)) d.dp  = 1'b1;
                    OPC_WAKE_ID: d.dp = 1'b0;
                    OPC_STAT_WR: begin
                        if (q.byte_cnt == BC_W'(2) && q.wel) begin
                            d.st_hi   = q.wr_hi;
                            d.start   = 1'b1;
                            d.kind    = KIND_STATUS;
                            d.op_addr = '0;
                        end
                    end
                    OPC_PROG: begin
                        if (q.byte_cnt >= BC_W'(5) && q.wel) begin
                            for (int i = 0; i < MEM_N; i++) begin
                                d.mem[i] = q.mem[i] & q.pbuf[i];
                            end
                            d.start   = 1'b1;
                            d.kind    = KIND_PROG;
                            d.op_addr = q.cmd_addr;
                        end
                    end
                    OPC_ERASE_SMALL, OPC_ERASE_BLK_A, OPC_ERASE_BLK_B: begin
                        if (q.byte_cnt == BC_W'(4) && q.wel) begin
                            d.mem     = '1;
                            d.start   = 1'b1;
                            d.kind    = KIND_ERASE;
                            d.op_addr = q.cmd_addr;
                        end
                    end
                    OPC_ERASE_ALL_A, OPC_ERASE_ALL_B: begin
                        if (q.byte_cnt == BC_W'(1) && q.wel) begin
                            d.mem     = '1;
                            d.start   = 1'b1;
                            d.kind    = KIND_ERASE_ALL;
                            d.op_addr = '0;
                        end
                    end
                    default: ;
                endcase
            end
            d.bit_cnt  = '0;
            d.byte_cnt = '0;
            d.drop     = 1'b0;
            d.out_sr   = '0;
            d.do_bit   = 1'b0;
        end else begin
            if (sck_fall) begin
                d.do_bit = q.out_sr[7];
                d.out_sr = {q.out_sr[6:0], 1'b0};
            end
            if (sck_rise) begin
                d.bit_cnt = q.bit_cnt + 3'd1;
                d.in_sr   = b[6:0];
                if (q.bit_cnt == 3'd7) begin
                    if (q.byte_cnt != BC_MAX) begin
                        d.byte_cnt = q.byte_cnt + BC_W'(1);
                    end
                    if (q.byte_cnt == '0) begin
                        d.opc      = b;
                        d.drop     = (busy_w && b != OPC_STAT_RD) ||
                                     (q.dp && b != OPC_WAKE_ID);
                        d.pbuf     = '1;
                        d.id_phase = 2'd0;
                        if (b == OPC_STAT_RD) begin
                            nxt = status;
                        end else if (b == OPC_ID_LONG) begin
                            nxt        = MAN_ID;
                            d.id_phase = 2'd1;
                        end
                        if (d.drop) nxt = 8'h00;
                    end else begin
                        case (q.opc)
                            OPC_STAT_RD: nxt = status;
                            OPC_STAT_WR: if (q.byte_cnt == BC_W'(1)) d.wr_hi = b[7:2];
                            OPC_RD, OPC_RD_FAST, OPC_PROG,
                            OPC_ERASE_SMALL, OPC_ERASE_BLK_A, OPC_ERASE_BLK_B: begin
                                if (q.byte_cnt <= BC_W'(3)) begin
                                    d.addr     = addr_now;
                                    d.cmd_addr = addr_now;
                                end
                                if ((q.opc == OPC_RD && q.byte_cnt >= BC_W'(3)) ||
                                    (q.opc == OPC_RD_FAST && q.byte_cnt >= BC_W'(4))) begin
                                    nxt    = q.mem[addr_now[MEM_AW-1:0]];
                                    d.addr = addr_now + ADDR_W'(1);
                                end
                                if (q.opc == OPC_PROG && q.byte_cnt >= BC_W'(4)) begin
                                    d.pbuf[q.addr[MEM_AW-1:0]] = b;
                                    d.addr = q.addr + ADDR_W'(1);
                                end
                            end
                            OPC_WAKE_ID: if (q.byte_cnt >= BC_W'(3)) nxt = DEV_ID;
                            OPC_ID_PAIR: begin
                                if (q.byte_cnt == BC_W'(3)) begin
                                    d.id_sel = b[0];
                                    nxt      = b[0] ? DEV_ID : MAN_ID;
                                end else if (q.byte_cnt > BC_W'(3)) begin
                                    d.id_sel = ~q.id_sel;
                                    nxt      = q.id_sel ? MAN_ID : DEV_ID;
                                end
                            end
                            OPC_ID_LONG: begin
                                case (q.id_phase)
                                    2'd0:    nxt = MAN_ID;
                                    2'd1:    nxt = LONG_ID[15:8];
                                    default: nxt = LONG_ID[7:0];
                                endcase
                                d.id_phase = (q.id_phase == 2'd2) ? 2'd0 : q.id_phase + 2'd1;
                            end
                            default: ;
                        endcase
                        if (q.drop) nxt = 8'h00;
                    end
                    d.out_sr = nxt;
                end
            end
        end

        if (busy_done) begin
            d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.csn_prev <= 1'b1;
            q.mem      <= '1;
            q.pbuf     <= '1;
        end else begin
            q <= d;
        end
    end

    assign do_o       = q.do_bit;
    assign wip_o      = busy_w;
    assign op_start_o = q.start;
    assign op_kind_o  = q.kind;
    assign op_addr_o  = q.op_addr;

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |-> q.wel); // R7

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |-> !wip_o); // R9

    AST_START_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |=> wip_o); // R8

    AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_o && busy_done) |=> !q.wel); // R8

    AST_SLEEP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        q.dp |-> !op_start_o); // R13

    AST_DO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_l && q.csn_prev) |=> !do_o); // R1

endmodule

// File: tb/test_spif_cmd_front.sv
module test_spif_cmd_front;

    localparam int HALF = 6;
    localparam int BUSY = 2000;
    localparam int N    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        csn = 1'b1;
    logic        di = 1'b0;
    logic        do_w;
    logic        wip;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [23:0] op_addr;

    int          n_chk = 0;
    int          n_fail = 0;
    int          n_starts = 0;
    logic [1:0]  last_kind = '0;
    logic [23:0] last_addr = '0;
    int          wip_run = 0;
    int          wip_len = 0;
    logic [7:0]  em [N];

    always #2 clk = ~clk;

    spif_cmd_front #(.BUSY_CYCLES(BUSY)) i_spif_cmd_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck),
        .csn_i      (csn),
        .di_i       (di),
        .do_o       (do_w),
        .wip_o      (wip),
        .op_start_o (op_start),
        .op_kind_o  (op_kind),
        .op_addr_o  (op_addr)
    );

    always @(posedge clk) begin
        if (op_start) begin
            n_starts  <= n_starts + 1;
            last_kind <= op_kind;
            last_addr <= op_addr;
        end
        if (wip) begin
            wip_run <= wip_run + 1;
        end else if (wip_run != 0) begin
            wip_len <= wip_run;
            wip_run <= 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        tick(1);
        csn = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_hi();
        tick(HALF);
        csn = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            di = tx[i];
            tick(HALF);
            rx[i] = do_w;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo();
        xb(op, r);
        cs_hi();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xb(a[23:16], r);
        xb(a[15:8], r);
        xb(a[7:0], r);
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        cs_lo();
        xb(8'h05, r);
        xb(8'h00, s);
        cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 100; i++) begin
            rd_status(s);
            if (!s[0]) break;
        end
    endtask

    task automatic rd_arr(input string req, input bit fast, input logic [23:0] a, input int cnt);
        logic [7:0] r;
        cs_lo();
        xb(fast ? 8'h0B : 8'h03, r);
        send_addr(a);
        if (fast) xb(8'h00, r);
        for (int j = 0; j < cnt; j++) begin
            xb(8'h00, r);
            chk(req, r, em[(int'(a[3:0]) + j) % N]);
        end
        cs_hi();
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) ^ (i << 4));
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] s;
        logic [7:0] ers [5];
        int         st0;

        ers[0] = 8'h20; ers[1] = 8'hD8; ers[2] = 8'h52; ers[3] = 8'hC7; ers[4] = 8'h60;
        for (int i = 0; i < N; i++) em[i] = 8'hFF;

        tick(5);
        chk("R1 reset do", int'(do_w), 0);
        chk("R8 reset wip", int'(wip), 0);
        rst_n = 1'b1;
        tick(5);

        // R1: status repeats, reset value 00h
        cs_lo();
        xb(8'h05, r);
        for (int j = 0; j < 3; j++) begin
            xb(8'h00, r);
            chk("R1 status reset", r, 8'h00);
        end
        cs_hi();

        // R2: write-enable set / clear
        cmd1(8'h06);
        cs_lo();
        xb(8'h05, r);
        for (int j = 0; j < 3; j++) begin
            xb(8'h00, r);
            chk("R2 wel set repeated", r, 8'h02);
        end
        cs_hi();
        cmd1(8'h04);
        rd_status(s); chk("R2 wel cleared", s, 8'h00);
        cs_lo(); xbits(8'h06, 5, r); cs_hi();
        rd_status(s); chk("R2 partial byte aborted", s, 8'h00);
        cs_lo(); xb(8'h06, r); xb(8'h00, r); cs_hi();
        rd_status(s); chk("R2 extra byte no effect", s, 8'h00);

        // R7: writes without write-enable
        cs_lo(); xb(8'h02, r); send_addr(24'h0); xb(8'h00, r); cs_hi();
        cs_lo(); xb(8'h20, r); send_addr(24'h0); cs_hi();
        cmd1(8'hC7);
        chk("R7 no request", n_starts, 0);
        rd_arr("R7 array kept", 1'b0, 24'h0, 4);

        // R4/R8: full-array program
        cmd1(8'h06);
        cs_lo(); xb(8'h02, r); send_addr(24'h123450);
        for (int i = 0; i < N; i++) begin
            xb(pat(i), r);
            em[i] = em[i] & pat(i);
        end
        cs_hi();
        chk("R8 one request", n_starts, 1);
        chk("R8 kind program", int'(last_kind), 1);
        chk("R8 request address", int'(last_addr), 24'h123450);
        rd_status(s); chk("R8 busy and wel", s, 8'h03);

        // R9: commands during busy are ignored
        cs_lo(); xb(8'h03, r); send_addr(24'h0);
        xb(8'h00, r); chk("R9 read ignored", r, 8'h00);
        xb(8'h00, r); chk("R9 read ignored", r, 8'h00);
        cs_hi();
        cmd1(8'h04);
        cs_lo(); xb(8'h20, r); send_addr(24'h0); cs_hi();
        rd_status(s); chk("R9 wel kept while busy", s, 8'h03);
        chk("R9 no request while busy", n_starts, 1);
        wait_idle();
        rd_status(s); chk("R8 wel cleared at end", s, 8'h00);
        chk("R8 busy length", wip_len, BUSY);

        // R3: read and fast read from every start address
        for (int a = 0; a < N; a++) rd_arr("R3 read", 1'b0, {20'h00F0A, 4'(a)}, 3);
        for (int a = 0; a < N; a++) rd_arr("R3 fast read", 1'b1, {20'h7A001, 4'(a)}, 3);

        // R4: wrapping program with AND
        cmd1(8'h06);
        cs_lo(); xb(8'h02, r); send_addr(24'h00000E);
        xb(8'h0F, r); xb(8'hF0, r); xb(8'h3C, r); xb(8'hC3, r);
        cs_hi();
        em[14] &= 8'h0F; em[15] &= 8'hF0; em[0] &= 8'h3C; em[1] &= 8'hC3;
        wait_idle();
        rd_arr("R4 wrap and", 1'b0, 24'h00000C, 8);

        // R2/R4: program cancelled mid-byte
        st0 = n_starts;
        cmd1(8'h06);
        cs_lo(); xb(8'h02, r); send_addr(24'h0); xb(8'h00, r); xbits(8'h00, 3, r); cs_hi();
        tick(2);
        chk("R4 aborted program no request", n_starts, st0);
        rd_status(s); chk("R2 aborted keeps wel", s, 8'h02);
        cmd1(8'h04);
        rd_arr("R4 aborted array kept", 1'b0, 24'h0, 2);

        // R6: status write
        cmd1(8'h06);
        cs_lo(); xb(8'h01, r); xb(8'hFF, r); cs_hi();
        chk("R6 kind status", int'(last_kind), 0);
        wait_idle();
        rd_status(s); chk("R6 stored bits", s, 8'hFC);
        cmd1(8'h06);
        cs_lo(); xb(8'h01, r); xb(8'h00, r); xb(8'h00, r); cs_hi();
        rd_status(s); chk("R6 wrong length ignored", s, 8'hFE);
        cmd1(8'h04);
        cs_lo(); xb(8'h01, r); xb(8'h00, r); cs_hi();
        rd_status(s); chk("R7 status write needs wel", s, 8'hFC);

        // R5: each erase opcode
        for (int e = 0; e < 5; e++) begin
            cmd1(8'h06);
            cs_lo(); xb(8'h02, r); send_addr(24'h000003); xb(8'h00, r); cs_hi();
            em[3] = 8'h00;
            wait_idle();
            cmd1(8'h06);
            cs_lo(); xb(ers[e], r);
            if (e < 3) begin
                xb(8'h00, r); xb(8'h00, r);
                cs_hi();
                tick(2);
                rd_status(s); chk("R5 short erase ignored", s, 8'h02 | 8'hFC);
                cs_lo(); xb(ers[e], r); send_addr(24'h000007);
            end
            cs_hi();
            chk("R5 erase kind", int'(last_kind), (e < 3) ? 2 : 3);
            for (int i = 0; i < N; i++) em[i] = 8'hFF;
            wait_idle();
            rd_arr("R5 erased", 1'b0, 24'h000002, 3);
        end

        // R10: short device ID
        cs_lo(); xb(8'hAB, r); xb(8'h00, r); xb(8'h00, r); xb(8'h00, r);
        for (int j = 0; j < 3; j++) begin
            xb(8'h00, r); chk("R10 device id", r, 8'h11);
        end
        cs_hi();

        // R11: alternating pair, both start choices
        for (int sel = 0; sel < 2; sel++) begin
            cs_lo(); xb(8'h90, r); xb(8'h00, r); xb(8'h00, r); xb(8'(sel), r);
            for (int j = 0; j < 4; j++) begin
                xb(8'h00, r);
                chk("R11 id pair", r, (((j + sel) % 2) == 0) ? 8'h1C : 8'h11);
            end
            cs_hi();
        end

        // R12: long identification
        cs_lo(); xb(8'h9F, r);
        for (int j = 0; j < 6; j++) begin
            xb(8'h00, r);
            chk("R12 long id", r, (j % 3 == 0) ? 8'h1C : ((j % 3 == 1) ? 8'h31 : 8'h12));
        end
        cs_hi();

        // R13: deep sleep
        cmd1(8'hB9);
        rd_status(s); chk("R13 status ignored asleep", s, 8'h00);
        cmd1(8'h06);
        cmd1(8'hAB);
        rd_status(s); chk("R13 wake, wel unchanged", s, 8'hFC);

        tick(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule